// File: doc/BRIEF.md
# Floating-Point Issue Reservation Tracker

This block decides, cycle by cycle, whether one floating-point operation offered to the issue stage may start now. It tracks four kinds of resource over a window of future cycles: the FP add unit, the FP multiply unit, two FP store/transfer ports, and two lower integer pipes that FP store and load traffic borrows. Each operation is presented with an operation class and a precision bit. The tracker grants it only if every slot it would occupy, at every offset it needs, is still free. When it grants, it books those slots and reports the operation's result latency. It also reports a second, longer latency that applies when the consumer is an FP store or an FP-to-integer move.

A requester whose operation is refused keeps presenting it. The tracker re-evaluates it every cycle and books nothing until the grant. Long operations such as divide and square root keep the add unit busy across many consecutive cycles. An FP conditional move claims the add unit twice, a fixed number of cycles apart. Store-type operations take a transfer port at issue and a lower integer pipe two cycles later.

The design has no state machine. All of its state is the per-unit busy windows, and the grant is a combinational function of these windows and the request.

Top module: `fp_resv_tracker`

## Requirements
- R1: While `rst_n` is low, `req_accept` is 0. After reset is released, every unit is free, so the first valid request is granted.
- R2: Class code 0 (add, copy-sign and FP branch) occupies the add unit for its issue cycle only and has latency 4. Such operations can be granted in consecutive cycles.
- R3: Class code 1 (multiply) occupies the multiply unit for its issue cycle only and has latency 4. Its grant does not depend on the add unit's state.
- R4: Class code 2 (divide) holds the add unit for 9 consecutive cycles with latency 12 when `req_dbl`=0. It holds the unit for 12 cycles with latency 15 when `req_dbl`=1.
- R5: Class code 3 (square root) holds the add unit for 15 consecutive cycles with latency 18 when `req_dbl`=0. It holds the unit for 30 cycles with latency 33 when `req_dbl`=1.
- R6: Class code 4 (conditional move) needs the add unit in its issue cycle and again 4 cycles later, with latency 8. The cycles in between remain free.
- R7: Class codes 5 (FP store) and 6 (FP-to-integer move) need a free transfer port at issue and a free lower integer pipe 2 cycles later, with latency 3. Class code 7 (FP load) needs a free lower integer pipe at issue, with latency 2. None of these uses the add or multiply unit.
- R8: `res_lat_st` is 6 for classes 0 and 1 and 10 for class 4. For every other class it equals `res_lat`.
- R9: When `req_accept` is 0, `res_lat` and `res_lat_st` are 0 and no slot is booked. A refused request therefore leaves later grants exactly as if it had never been presented.
- R10: A request is granted only if `req_valid` is 1 and every slot it needs is free at its offset. No slot is ever booked twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An FP operation is offered this cycle |
| req_op | input | 3 | Operation class code (0..7, see requirements) |
| req_dbl | input | 1 | 1 = double precision, 0 = single |
| req_accept | output | 1 | Operation granted and its slots booked |
| res_lat | output | 6 | Cycles from issue until the result is ready (0 when not granted) |
| res_lat_st | output | 6 | Result latency seen by a store or FP-to-integer consumer (0 when not granted) |

## Verification
Several properties are checked on every cycle:
- No unit's window is ever claimed where it is already busy.
- A refused cycle only ages the add unit's window.
- Both latency outputs are zero whenever there is no grant, and the store-consumer latency never falls below the plain latency.
- The cycle after a double-precision square root grant, no add-unit operation is granted.

The exact hold lengths of divide and square root need the bench's reference model, because a property cannot count them. The same applies to the second add-unit claim of a conditional move and to the number of refusals a held request sees before its grant. The bench compares all outputs against that model on every clock.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

    typedef enum logic [2:0] {
        OP_FADD   = 3'd0,
        OP_FMUL   = 3'd1,
        OP_FDIV   = 3'd2,
        OP_FSQRT  = 3'd3,
        OP_FCMOV  = 3'd4,
        OP_FSTORE = 3'd5,
        OP_FTOI   = 3'd6,
        OP_FLOAD  = 3'd7
    } fp_op_e;

    localparam int LAT_SIMPLE   = 4;
    localparam int LAT_SIMPLE_S = 6;
    localparam int HOLD_DIV_S   = 9;
    localparam int HOLD_DIV_D   = 12;
    localparam int HOLD_SQRT_S  = 15;
    localparam int HOLD_SQRT_D  = 30;
    localparam int TAIL_LONG    = 3;
    localparam int CMOV_GAP     = 4;
    localparam int LAT_CMOV     = 8;
    localparam int LAT_CMOV_S   = 10;
    localparam int LOW_OFS      = 2;
    localparam int LAT_XFER     = 3;
    localparam int LAT_LOAD     = 2;

endpackage

// File: rtl/fpr_unit_track.sv
module fpr_unit_track #(
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] claim,
    output logic [DEPTH-1:0] busy
);

    // bit k of busy = unit occupied k cycles from now
    always_ff @(posedge clk) begin
        if (!rst_n) busy <= '0;
        else        busy <= (busy | claim) >> 1;
    end

    AST_NO_DOUBLE_BOOK: assert property (@(posedge clk) disable iff (!rst_n)
        (claim & busy) == '0) else $error("slot booked twice"); // R10

endmodule

// File: rtl/fpr_need_decode.sv
module fpr_need_decode #(
    parameter int DEPTH = 32,
    parameter int LATW  = 6
) (
    input  fpr_pkg::fp_op_e  op,
    input  logic             dbl,
    output logic [DEPTH-1:0] fa_need,
    output logic [DEPTH-1:0] fm_need,
    output logic [DEPTH-1:0] low_need,
    output logic             fst_need,
    output logic [LATW-1:0]  lat,
    output logic [LATW-1:0]  lat_st
);
    import fpr_pkg::*;

    function automatic logic [DEPTH-1:0] span(input int n);
        logic [DEPTH-1:0] m;
        for (int i = 0; i < DEPTH; i++) m[i] = (i < n);
        return m;
    endfunction

    always_comb begin
        fa_need  = '0;
        fm_need  = '0;
        low_need = '0;
        fst_need = 1'b0;
        lat      = '0;
        lat_st   = '0;
        unique case (op)
            OP_FADD: begin
                fa_need[0] = 1'b1;
                lat        = LATW'(LAT_SIMPLE);
                lat_st     = LATW'(LAT_SIMPLE_S);
            end
            OP_FMUL: begin
                fm_need[0] = 1'b1;
                lat        = LATW'(LAT_SIMPLE);
                lat_st     = LATW'(LAT_SIMPLE_S);
            end
            OP_FDIV: begin
                fa_need = span(dbl ? HOLD_DIV_D : HOLD_DIV_S);
                lat     = LATW'((dbl ? HOLD_DIV_D : HOLD_DIV_S) + TAIL_LONG);
                lat_st  = lat;
            end
            OP_FSQRT: begin
                fa_need = span(dbl ? HOLD_SQRT_D : HOLD_SQRT_S);
                lat     = LATW'((dbl ? HOLD_SQRT_D : HOLD_SQRT_S) + TAIL_LONG);
                lat_st  = lat;
            end
            OP_FCMOV: begin
                fa_need[0]        = 1'b1;
                fa_need[CMOV_GAP] = 1'b1;
                lat               = LATW'(LAT_CMOV);
                lat_st            = LATW'(LAT_CMOV_S);
            end
            OP_FSTORE, OP_FTOI: begin
                fst_need          = 1'b1;
                low_need[LOW_OFS] = 1'b1;
                lat               = LATW'(LAT_XFER);
                lat_st            = LATW'(LAT_XFER);
            end
            OP_FLOAD: begin
                low_need[0] = 1'b1;
                lat         = LATW'(LAT_LOAD);
                lat_st      = LATW'(LAT_LOAD);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fp_resv_tracker.sv
module fp_resv_tracker #(
    parameter int DEPTH = 32,
    parameter int LATW  = 6,
    parameter int NFST  = 2,
    parameter int NLOW  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_op,
    input  logic            req_dbl,
    output logic            req_accept,
    output logic [LATW-1:0] res_lat,
    output logic [LATW-1:0] res_lat_st
);
    import fpr_pkg::*;

    localparam int FPW = (NFST > 1) ? $clog2(NFST) : 1;
    localparam int LPW = (NLOW > 1) ? $clog2(NLOW) : 1;

    fp_op_e           op;
    logic [DEPTH-1:0] fa_need, fm_need, low_need;
    logic             fst_need;
    logic [LATW-1:0]  lat, lat_st;
    logic [DEPTH-1:0] fa_busy, fm_busy;
    logic [DEPTH-1:0] fa_claim, fm_claim;
    logic             fst_busy  [NFST];
    logic             fst_claim [NFST];
    logic [DEPTH-1:0] low_busy  [NLOW];
    logic [DEPTH-1:0] low_claim [NLOW];
    logic [FPW-1:0]   fst_pick;
    logic [LPW-1:0]   low_pick;
    logic             fst_found, low_found, fits;

    assign op = fp_op_e'(req_op);

    fpr_need_decode #(.DEPTH(DEPTH), .LATW(LATW)) dec_i (
        .op(op), .dbl(req_dbl), .fa_need(fa_need), .fm_need(fm_need),
        .low_need(low_need), .fst_need(fst_need), .lat(lat), .lat_st(lat_st)
    );

    fpr_unit_track #(.DEPTH(DEPTH)) fa_i (
        .clk(clk), .rst_n(rst_n), .claim(fa_claim), .busy(fa_busy));
    fpr_unit_track #(.DEPTH(DEPTH)) fm_i (
        .clk(clk), .rst_n(rst_n), .claim(fm_claim), .busy(fm_busy));

    // a transfer port is held only in its issue cycle: one bit per port
    for (genvar g = 0; g < NFST; g++) begin : g_fst
        fpr_unit_track #(.DEPTH(1)) trk_i (
            .clk(clk), .rst_n(rst_n), .claim(fst_claim[g]), .busy(fst_busy[g]));
        assign fst_claim[g] = req_accept && fst_need && (fst_pick == FPW'(g));
    end

    for (genvar g = 0; g < NLOW; g++) begin : g_low
        fpr_unit_track #(.DEPTH(DEPTH)) trk_i (
            .clk(clk), .rst_n(rst_n), .claim(low_claim[g]), .busy(low_busy[g]));
        assign low_claim[g] = (req_accept && (low_pick == LPW'(g))) ? low_need : '0;
    end

    // lowest-numbered free resource wins
    always_comb begin
        fst_pick  = '0;
        fst_found = 1'b0;
        for (int g = 0; g < NFST; g++) begin
            if (!fst_found && !fst_busy[g]) begin
                fst_pick  = FPW'(g);
                fst_found = 1'b1;
            end
        end
        low_pick  = '0;
        low_found = 1'b0;
        for (int g = 0; g < NLOW; g++) begin
            if (!low_found && ((low_need & low_busy[g]) == '0)) begin
                low_pick  = LPW'(g);
                low_found = 1'b1;
            end
        end
    end

    assign fits = ((fa_need & fa_busy) == '0) && ((fm_need & fm_busy) == '0)
                  && (!fst_need || fst_found) && low_found;

    assign req_accept = rst_n && req_valid && fits;
    assign fa_claim   = req_accept ? fa_need : '0;
    assign fm_claim   = req_accept ? fm_need : '0;
    assign res_lat    = req_accept ? lat    : '0;
    assign res_lat_st = req_accept ? lat_st : '0;

    AST_IDLE_ZERO_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        !req_accept |-> (res_lat == '0 && res_lat_st == '0)) else $error("lat w/o grant"); // R9

    AST_REFUSE_ONLY_AGES: assert property (@(posedge clk) disable iff (!rst_n)
        !req_accept |=> fa_busy == ($past(fa_busy) >> 1)) else $error("refused op booked"); // R9

    AST_GRANT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        req_accept |-> req_valid) else $error("grant without request"); // R10

    AST_ST_LAT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        req_accept |-> res_lat_st >= res_lat) else $error("store latency short"); // R8

    AST_LONG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_accept && op == OP_FSQRT && req_dbl)
        |=> !(req_accept && (op == OP_FADD || op == OP_FDIV || op == OP_FSQRT || op == OP_FCMOV)))
        else $error("add unit reused during root"); // R5

endmodule

// File: tb/fp_resv_tracker_tb_top.sv
`timescale 1ns/1ps
module fp_resv_tracker_tb_top;
    import fpr_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = 3'd0;
    logic       req_dbl = 1'b0;
    logic       req_accept;
    logic [5:0] res_lat, res_lat_st;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit last_acc;

    bit fa_b [int];
    bit fm_b [int];
    int low_cnt [int];

    always #2 clk = ~clk;

    fp_resv_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_dbl(req_dbl), .req_accept(req_accept), .res_lat(res_lat),
        .res_lat_st(res_lat_st));

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", tag, what, act, exp, cyc);
        end
    endtask

    // one clock: drive, compare against the model, then book in the model
    task automatic step(input bit v, input fp_op_e o, input bit d, input string tag);
        int fa_offs[$];
        int low_ofs;
        bit use_fm;
        bit ok;
        int el, es;
        @(negedge clk);
        req_valid = v; req_op = o; req_dbl = d;
        #1;
        low_ofs = -1; use_fm = 0; el = 0; es = 0;
        case (o)
            OP_FADD:  begin fa_offs.push_back(0); el = 4; es = 6; end
            OP_FMUL:  begin use_fm = 1; el = 4; es = 6; end
            OP_FDIV:  begin for (int i = 0; i < (d ? 12 : 9); i++) fa_offs.push_back(i);
                            el = d ? 15 : 12; es = el; end
            OP_FSQRT: begin for (int i = 0; i < (d ? 30 : 15); i++) fa_offs.push_back(i);
                            el = d ? 33 : 18; es = el; end
            OP_FCMOV: begin fa_offs.push_back(0); fa_offs.push_back(4); el = 8; es = 10; end
            OP_FSTORE, OP_FTOI: begin low_ofs = 2; el = 3; es = 3; end
            default:  begin low_ofs = 0; el = 2; es = 2; end
        endcase
        ok = v && rst_n;
        foreach (fa_offs[k]) if (fa_b.exists(cyc + fa_offs[k])) ok = 0;
        if (use_fm && fm_b.exists(cyc)) ok = 0;
        if (low_ofs >= 0 && low_cnt.exists(cyc + low_ofs) && low_cnt[cyc + low_ofs] >= 2) ok = 0;
        chk(tag, int'(req_accept), int'(ok), "accept");
        chk(tag, int'(res_lat), ok ? el : 0, "res_lat");
        chk(tag, int'(res_lat_st), ok ? es : 0, "res_lat_st");
        if (ok) begin
            foreach (fa_offs[k]) fa_b[cyc + fa_offs[k]] = 1;
            if (use_fm) fm_b[cyc] = 1;
            if (low_ofs >= 0) begin
                if (low_cnt.exists(cyc + low_ofs)) low_cnt[cyc + low_ofs]++;
                else low_cnt[cyc + low_ofs] = 1;
            end
        end
        last_acc = ok;
        cyc++;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, OP_FADD, 0, tag);
    endtask

    // keep presenting until granted; count refusals
    task automatic hold(input fp_op_e o, input bit d, input string tag, output int waits);
        waits = 0;
        for (int i = 0; i < 50; i++) begin
            step(1, o, d, tag);
            if (last_acc) break;
            waits++;
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        int w;
        // R1: no grant in reset
        step(1, OP_FADD, 0, "R1");
        step(1, OP_FMUL, 0, "R1");
        @(negedge clk); rst_n = 1'b1;
        cyc++;
        idle(1, "R9");
        step(1, OP_FSQRT, 1, "R1");
        idle(32, "R9");

        // R2: back-to-back adds
        for (int i = 0; i < 4; i++) step(1, OP_FADD, 0, "R2");
        // R3: multiply alongside a busy add unit
        step(1, OP_FDIV, 0, "R3");
        step(1, OP_FMUL, 0, "R3");
        step(1, OP_FMUL, 0, "R3");
        hold(OP_FADD, 0, "R4", w);
        chk("R4", w, 6, "single divide refusals after two muls");
        idle(2, "R9");

        // R4: divide hold lengths
        step(1, OP_FDIV, 0, "R4");
        hold(OP_FADD, 0, "R4", w);
        chk("R4", w, 8, "single divide refusals");
        step(1, OP_FDIV, 1, "R4");
        hold(OP_FADD, 0, "R4", w);
        chk("R4", w, 11, "double divide refusals");

        // R5: square root hold lengths
        step(1, OP_FSQRT, 0, "R5");
        hold(OP_FCMOV, 0, "R5", w);
        chk("R5", w, 14, "single root refusals");
        idle(5, "R9");
        step(1, OP_FSQRT, 1, "R5");
        hold(OP_FDIV, 0, "R5", w);
        chk("R5", w, 29, "double root refusals");
        idle(12, "R9");

        // R6: conditional move second claim
        step(1, OP_FCMOV, 0, "R6");
        step(1, OP_FADD, 0, "R6");
        step(1, OP_FADD, 0, "R6");
        step(1, OP_FADD, 0, "R6");
        hold(OP_FADD, 0, "R6", w);
        chk("R6", w, 1, "add in second cmov slot");
        step(1, OP_FCMOV, 0, "R6");
        idle(3, "R6");
        hold(OP_FCMOV, 0, "R6", w);
        chk("R6", w, 1, "cmov against cmov second slot");
        idle(6, "R9");

        // R7: transfers and loads, independent of the add unit
        step(1, OP_FDIV, 1, "R7");
        step(1, OP_FSTORE, 0, "R7");
        step(1, OP_FTOI, 0, "R7");
        step(1, OP_FLOAD, 0, "R7");
        step(1, OP_FLOAD, 0, "R7");
        step(1, OP_FSTORE, 1, "R7");
        step(1, OP_FMUL, 0, "R7");
        idle(8, "R9");

        // R8: store-consumer latencies per class
        step(1, OP_FADD, 0, "R8");
        step(1, OP_FMUL, 0, "R8");
        idle(1, "R8");
        step(1, OP_FCMOV, 0, "R8");
        step(1, OP_FTOI, 0, "R8");
        idle(6, "R8");

        // R9/R10: refused cmov attempts must not book its later slot
        step(1, OP_FDIV, 0, "R10");
        for (int i = 0; i < 3; i++) step(1, OP_FCMOV, 0, "R9");
        idle(5, "R9");
        for (int i = 0; i < 6; i++) step(1, OP_FADD, 0, "R9");
        step(0, OP_FSQRT, 1, "R10");
        step(1, OP_FADD, 0, "R10");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule